// File: doc/BRIEF.md
# Scanline timing and STAT interrupt generator

This block is the timing core of a dot-matrix display controller. While the display is switched on it steps a position counter through each scanline and each frame, and from that position it produces the current line number, the two-bit display mode, the line-compare match flag and two interrupt request pulses. One request marks the start of vertical blanking. The other marks a new rising edge of the status-interrupt level, which is the OR of four selectable sources. It also keeps an effective vertical-scroll copy for the pixel fetcher. That copy is resampled at each 8-pixel tile boundary of the visible part of a line.

Each clock edge with the display on is one step. A step advances the position by 4 dots at normal speed and by 2 dots at double speed. A line is 456 dots long, a frame is 154 lines, and vertical blanking covers lines 144 to 153. The first line after the display is switched on is 4 dots short. A color-model select adds a deferral mask. The mask flags every request raised in the current cycle, so an interrupt controller can hold that request back for one cycle.

Top module: `lcd_timing_engine`

## Requirements
- R1: While reset is active or `lcd_on` is low, `ly`, `mode`, `lyc_match`, both request pulses and `irq_defer` are 0. `eff_scy` resets to 0 and keeps its value while the display is off.
- R2: On the first clock edge that sees `lcd_on` high after it was low, the position becomes dot 0 of line 0 (`ly`=0, `mode`=2) and no request is raised on that edge.
- R3: Each later edge with `lcd_on` high advances the dot position by 4, or by 2 when `dbl_speed` is 1. `ly` is the frame position divided by 456 and wraps from 153 to 0.
- R4: The first line after switch-on ends 4 dots early. At normal speed it lasts 113 steps (every other line lasts 114). At double speed it lasts 226 steps (every other line lasts 228).
- R5: Mode codes: 2 for dots 0–79, 3 for dots 80–251 and 0 for dots 252–455 on lines 0–143. Mode 1 applies on lines 144–153.
- R6: `irq_vblank` is high for exactly one cycle, on the edge where `ly` becomes 144.
- R7: `lyc_match` is 1 exactly when `ly` equals the `lyc` value sampled at the same edge.
- R8: The status level is the OR of `stat_src_en[0]`&mode 0, `stat_src_en[1]`&mode 1, `stat_src_en[2]`&mode 2 and `stat_src_en[3]`&`lyc_match`. `irq_stat` pulses for one cycle only when this level goes from 0 to 1 between two steps. It does not pulse while the level stays high.
- R9: With `color_mode`=1, `irq_defer[0]` equals `irq_vblank` and `irq_defer[1]` equals `irq_stat` in the same cycle. With `color_mode`=0, `irq_defer` is 0.
- R10: With x = dot − 80 − (`scx` mod 8) − 7, `eff_scy` loads `scy` on the step whose covered dots include an x with −8 ≤ x < 160 and (x + `scx`) mod 8 = 0, on lines 0–143.
- R11: Outside that window, and in particular during mode 0 and vertical blanking, `eff_scy` holds its value while `scy` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_on | input | 1 | Display enable |
| dbl_speed | input | 1 | 1: 2 dots per step, 0: 4 dots per step |
| color_mode | input | 1 | Enables the deferral mask |
| scx | input | 8 | Horizontal scroll |
| scy | input | 8 | Vertical scroll |
| lyc | input | 8 | Line-compare value |
| stat_src_en | input | 4 | Status sources: [0] mode 0, [1] mode 1, [2] mode 2, [3] line match |
| ly | output | 8 | Current line number |
| mode | output | 2 | Display mode code |
| lyc_match | output | 1 | Line-compare equality flag |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_stat | output | 1 | Status request pulse |
| irq_defer | output | 2 | One-cycle deferral mask: [0] vblank, [1] status |
| eff_scy | output | 8 | Latched vertical scroll for the fetcher |

## Verification
Every output is registered behind a reset synchronizer. After the switch-on edge, step n leaves the dot position at 4n (2n at double speed). Line L ≥ 1 begins after 113 + 114·(L−1) steps. Mode, line, match and both pulses therefore change on the same edge as the counter, and a scroll load appears on the edge whose previous dot position covers the tile boundary. The bench counts edges from switch-on and samples on the falling edge that follows the predicted step and the step before it. This confirms both the arrival of each event and its absence one cycle earlier.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    MODE_HBL  = 2'd0,
    MODE_VBL  = 2'd1,
    MODE_OAM  = 2'd2,
    MODE_DRAW = 2'd3
  } lcd_mode_e;

  localparam int SRC_HBL   = 0;
  localparam int SRC_VBL   = 1;
  localparam int SRC_OAM   = 2;
  localparam int SRC_MATCH = 3;

endpackage

// File: rtl/lcdt_line_counter.sv
module lcdt_line_counter #(
  parameter int LINE_DOTS   = 456,
  parameter int FRAME_LINES = 154,
  parameter int FIRST_CUT   = 4,
  parameter int STEP_NORM   = 4,
  parameter int STEP_FAST   = 2,
  parameter int DOT_W       = 9,
  parameter int LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              stop,
  input  logic              dbl,
  output logic [DOT_W-1:0]  dot_q,
  output logic [DOT_W-1:0]  dot_d,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_d
);

  localparam int SUM_W = DOT_W + 1;
  localparam logic [SUM_W-1:0]  LINE_S  = SUM_W'(LINE_DOTS);
  localparam logic [SUM_W-1:0]  CUT_AT  = SUM_W'(LINE_DOTS - FIRST_CUT);
  localparam logic [SUM_W-1:0]  CUT_S   = SUM_W'(FIRST_CUT);
  localparam logic [SUM_W-1:0]  STEP_N  = SUM_W'(STEP_NORM);
  localparam logic [SUM_W-1:0]  STEP_F  = SUM_W'(STEP_FAST);
  localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(FRAME_LINES - 1);

  logic             first_q, first_d;
  logic [SUM_W-1:0] sum_raw, sum_adj;
  logic             cnt_en;

  assign cnt_en = start | run | stop;

  always_comb begin
    sum_raw = {1'b0, dot_q} + (dbl ? STEP_F : STEP_N);
    sum_adj = sum_raw;
    first_d = first_q;
    if (first_q && (sum_raw >= CUT_AT)) begin
      sum_adj = sum_raw + CUT_S;
      first_d = 1'b0;
    end
    if (sum_adj >= LINE_S) begin
      dot_d  = DOT_W'(sum_adj - LINE_S);
      line_d = (line_q == LAST_L) ? '0 : line_q + 1'b1;
    end else begin
      dot_d  = sum_adj[DOT_W-1:0];
      line_d = line_q;
    end
    if (start) begin
      dot_d   = '0;
      line_d  = '0;
      first_d = 1'b1;
    end else if (stop) begin
      dot_d   = '0;
      line_d  = '0;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b0;
    end else if (cnt_en) begin
      dot_q   <= dot_d;
      line_q  <= line_d;
      first_q <= first_d;
    end
  end

  p_dot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dot_q < DOT_W'(LINE_DOTS));

  p_line_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < LINE_W'(FRAME_LINES));

endmodule

// File: rtl/lcdt_mode_decode.sv
module lcdt_mode_decode
  import lcdt_pkg::*;
#(
  parameter int OAM_DOTS  = 80,
  parameter int DRAW_DOTS = 172,
  parameter int VIS_LINES = 144,
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 8
) (
  input  logic              on,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic [7:0]        lyc,
  input  logic [3:0]        src_en,
  output lcd_mode_e         mode,
  output logic              match,
  output logic              level
);

  localparam logic [DOT_W-1:0]  OAM_END  = DOT_W'(OAM_DOTS);
  localparam logic [DOT_W-1:0]  DRAW_END = DOT_W'(OAM_DOTS + DRAW_DOTS);
  localparam logic [LINE_W-1:0] VBL_L    = LINE_W'(VIS_LINES);

  always_comb begin
    if (!on)                mode = MODE_HBL;
    else if (line >= VBL_L) mode = MODE_VBL;
    else if (dot < OAM_END) mode = MODE_OAM;
    else if (dot < DRAW_END) mode = MODE_DRAW;
    else                    mode = MODE_HBL;

    match = on && (line == LINE_W'(lyc));

    level = on && ((src_en[SRC_HBL]   && mode == MODE_HBL) ||
                   (src_en[SRC_VBL]   && mode == MODE_VBL) ||
                   (src_en[SRC_OAM]   && mode == MODE_OAM) ||
                   (src_en[SRC_MATCH] && match));
  end

endmodule

// File: rtl/lcdt_scroll_latch.sv
module lcdt_scroll_latch #(
  parameter int MAX_STEP   = 4,
  parameter int OAM_DOTS   = 80,
  parameter int FETCH_LEAD = 7,
  parameter int PRE_DOTS   = 8,
  parameter int VIS_WIDTH  = 160,
  parameter int VIS_LINES  = 144,
  parameter int DOT_W      = 9,
  parameter int LINE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [2:0]        step_sz,
  input  logic [DOT_W-1:0]  dot_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic [7:0]        scx,
  input  logic [7:0]        scy,
  output logic [7:0]        eff_scy
);

  localparam int XW = DOT_W + 3;
  localparam logic signed [XW-1:0] X_OFS = XW'(OAM_DOTS + FETCH_LEAD);
  localparam logic signed [XW-1:0] X_LO  = XW'(-PRE_DOTS);
  localparam logic signed [XW-1:0] X_HI  = XW'(VIS_WIDTH);
  localparam logic [LINE_W-1:0]    VBL_L = LINE_W'(VIS_LINES);

  logic [MAX_STEP-1:0] hit_k;
  logic                load;

  for (genvar k = 0; k < MAX_STEP; k++) begin : g_pos
    logic signed [XW-1:0] x_pos;
    logic [2:0]           phase;
    assign x_pos = $signed({3'b000, dot_q}) + $signed(XW'(k)) - X_OFS
                   - $signed({{(XW-3){1'b0}}, scx[2:0]});
    assign phase = x_pos[2:0] + scx[2:0];
    assign hit_k[k] = (3'(k) < step_sz) && (x_pos >= X_LO) && (x_pos < X_HI)
                      && (phase == 3'd0);
  end

  assign load = run && (line_q < VBL_L) && (|hit_k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_scy <= '0;
    end else if (load) begin
      eff_scy <= scy;
    end
  end

endmodule

// File: rtl/lcd_timing_engine.sv
module lcd_timing_engine
  import lcdt_pkg::*;
#(
  parameter int LINE_DOTS   = 456,
  parameter int OAM_DOTS    = 80,
  parameter int DRAW_DOTS   = 172,
  parameter int FRAME_LINES = 154,
  parameter int VIS_LINES   = 144,
  parameter int VIS_WIDTH   = 160,
  parameter int FIRST_CUT   = 4,
  parameter int STEP_NORM   = 4,
  parameter int STEP_FAST   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lcd_on,
  input  logic       dbl_speed,
  input  logic       color_mode,
  input  logic [7:0] scx,
  input  logic [7:0] scy,
  input  logic [7:0] lyc,
  input  logic [3:0] stat_src_en,
  output logic [7:0] ly,
  output logic [1:0] mode,
  output logic       lyc_match,
  output logic       irq_vblank,
  output logic       irq_stat,
  output logic [1:0] irq_defer,
  output logic [7:0] eff_scy
);

  localparam int DOT_W  = $clog2(LINE_DOTS);
  localparam int LINE_W = 8;
  localparam int MAX_STEP = (STEP_NORM > STEP_FAST) ? STEP_NORM : STEP_FAST;
  localparam logic [LINE_W-1:0] VBL_L  = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] PRE_VB = LINE_W'(VIS_LINES - 1);

  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic              on_q;
  logic              start, run, stop, reg_en;
  logic [DOT_W-1:0]  dot_q, dot_d;
  logic [LINE_W-1:0] line_q, line_d;

  assign start  = lcd_on & ~on_q;
  assign run    = lcd_on & on_q;
  assign stop   = ~lcd_on & on_q;
  assign reg_en = lcd_on | on_q;

  lcdt_line_counter #(
    .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES), .FIRST_CUT(FIRST_CUT),
    .STEP_NORM(STEP_NORM), .STEP_FAST(STEP_FAST), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .start(start), .run(run), .stop(stop),
    .dbl(dbl_speed), .dot_q(dot_q), .dot_d(dot_d), .line_q(line_q), .line_d(line_d)
  );

  lcd_mode_e mode_d, mode_q;
  logic      match_d, match_q, lvl_d, lvl_q;

  lcdt_mode_decode #(
    .OAM_DOTS(OAM_DOTS), .DRAW_DOTS(DRAW_DOTS), .VIS_LINES(VIS_LINES),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_dec (
    .on(lcd_on), .dot(dot_d), .line(line_d), .lyc(lyc), .src_en(stat_src_en),
    .mode(mode_d), .match(match_d), .level(lvl_d)
  );

  logic [2:0] step_sz;
  assign step_sz = dbl_speed ? 3'(STEP_FAST) : 3'(STEP_NORM);

  lcdt_scroll_latch #(
    .MAX_STEP(MAX_STEP), .OAM_DOTS(OAM_DOTS), .FETCH_LEAD(7), .PRE_DOTS(8),
    .VIS_WIDTH(VIS_WIDTH), .VIS_LINES(VIS_LINES), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_scy (
    .clk(clk), .rst_n(rst_s_n), .run(run), .step_sz(step_sz), .dot_q(dot_q),
    .line_q(line_q), .scx(scx), .scy(scy), .eff_scy(eff_scy)
  );

  logic       vbl_req, stat_req;
  logic [1:0] defer_d;
  logic       vbl_q, stat_q;
  logic [1:0] defer_q;

  always_comb begin
    vbl_req  = run && (line_q == PRE_VB) && (line_d == VBL_L);
    stat_req = run && lvl_d && !lvl_q;
    defer_d  = {stat_req, vbl_req} & {2{color_mode}};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) on_q <= 1'b0;
    else          on_q <= lcd_on;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q  <= MODE_HBL;
      match_q <= 1'b0;
      lvl_q   <= 1'b0;
      vbl_q   <= 1'b0;
      stat_q  <= 1'b0;
      defer_q <= 2'b00;
    end else if (reg_en) begin
      mode_q  <= mode_d;
      match_q <= match_d;
      lvl_q   <= lvl_d;
      vbl_q   <= vbl_req;
      stat_q  <= stat_req;
      defer_q <= defer_d;
    end
  end

  assign ly         = line_q;
  assign mode       = mode_q;
  assign lyc_match  = match_q;
  assign irq_vblank = vbl_q;
  assign irq_stat   = stat_q;
  assign irq_defer  = defer_q;

  p_vbl_entry_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_vblank |-> (ly == VBL_L && mode == 2'd1));

  p_stat_single_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_stat |=> !irq_stat);

  p_defer_subset_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_defer & ~{irq_stat, irq_vblank}) == 2'b00);

  p_match_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (on_q && $past(on_q)) |-> (lyc_match == ($past(lyc) == ly)));

  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (on_q && $past(on_q) && ly != $past(ly)) |-> (ly == $past(ly) + 8'd1 || ly == 8'd0));

  p_scroll_hold_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((mode == 2'd0 || mode == 2'd1) && mode == $past(mode) && $past(on_q))
      |-> $stable(eff_scy));

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    !on_q |-> (!irq_vblank && !irq_stat && irq_defer == 2'b00));

endmodule

// File: tb/tb_lcd_timing_engine.sv
`timescale 1ns/1ps
module tb_lcd_timing_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lcd_on, dbl_speed, color_mode;
  logic [7:0] scx, scy, lyc;
  logic [3:0] stat_src_en;
  logic [7:0] ly;
  logic [1:0] mode;
  logic       lyc_match, irq_vblank, irq_stat;
  logic [1:0] irq_defer;
  logic [7:0] eff_scy;

  int n_chk  = 0;
  int n_fail = 0;
  int steps  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lcd_timing_engine dut (
    .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .dbl_speed(dbl_speed),
    .color_mode(color_mode), .scx(scx), .scy(scy), .lyc(lyc),
    .stat_src_en(stat_src_en), .ly(ly), .mode(mode), .lyc_match(lyc_match),
    .irq_vblank(irq_vblank), .irq_stat(irq_stat), .irq_defer(irq_defer),
    .eff_scy(eff_scy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (step %0d)", req, what, act, exp, steps);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic advance(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    steps += n;
  endtask

  task automatic goto_step(input int target);
    advance(target - steps);
  endtask

  task automatic lcd_start(input bit dbl, input bit col);
    lcd_on = 1'b0;
    advance(2);
    dbl_speed  = dbl;
    color_mode = col;
    lcd_on     = 1'b1;
    advance(1);
    steps = 0;
  endtask

  task automatic t_reset;
    chk_eq("R1", "ly after reset", ly, 0);
    chk_eq("R1", "mode after reset", mode, 0);
    chk_eq("R1", "match after reset", lyc_match, 0);
    chk_eq("R1", "vblank req after reset", irq_vblank, 0);
    chk_eq("R1", "stat req after reset", irq_stat, 0);
    chk_eq("R1", "defer after reset", irq_defer, 0);
    chk_eq("R1", "eff_scy after reset", eff_scy, 0);
  endtask

  task automatic t_modes;
    lcd_start(1'b0, 1'b0);
    chk_eq("R2", "ly on switch-on", ly, 0);
    chk_eq("R2", "mode on switch-on", mode, 2);
    chk_eq("R2", "stat req on switch-on", irq_stat, 0);
    goto_step(19);  chk_eq("R5", "mode at dot 76", mode, 2);
    goto_step(20);  chk_eq("R5", "mode at dot 80", mode, 3);
    goto_step(62);  chk_eq("R5", "mode at dot 248", mode, 3);
    goto_step(63);  chk_eq("R5", "mode at dot 252", mode, 0);
    goto_step(112); chk_eq("R4", "ly before short line end", ly, 0);
    goto_step(113); chk_eq("R4", "ly after short first line", ly, 1);
    chk_eq("R5", "mode at line 1 start", mode, 2);
    goto_step(226); chk_eq("R3", "ly late in line 1", ly, 1);
    goto_step(227); chk_eq("R3", "ly after full line", ly, 2);
  endtask

  task automatic t_double;
    lcd_start(1'b1, 1'b0);
    goto_step(39);  chk_eq("R3", "dbl mode at dot 78", mode, 2);
    goto_step(40);  chk_eq("R3", "dbl mode at dot 80", mode, 3);
    goto_step(225); chk_eq("R4", "dbl ly before short end", ly, 0);
    goto_step(226); chk_eq("R4", "dbl ly after short line", ly, 1);
    goto_step(453); chk_eq("R3", "dbl ly late line 1", ly, 1);
    goto_step(454); chk_eq("R3", "dbl ly after full line", ly, 2);
    dbl_speed = 1'b0;
  endtask

  task automatic t_vblank;
    lcd_start(1'b0, 1'b1);
    goto_step(16414);
    chk_eq("R6", "ly before vblank", ly, 143);
    chk_eq("R6", "vblank req early", irq_vblank, 0);
    goto_step(16415);
    chk_eq("R6", "ly at vblank", ly, 144);
    chk_eq("R5", "mode at vblank", mode, 1);
    chk_eq("R6", "vblank req", irq_vblank, 1);
    chk_eq("R9", "defer at vblank (color)", irq_defer, 1);
    goto_step(16416);
    chk_eq("R6", "vblank req one cycle", irq_vblank, 0);
    chk_eq("R9", "defer cleared", irq_defer, 0);
    goto_step(17554);
    chk_eq("R3", "ly last line", ly, 153);
    chk_eq("R5", "mode last line", mode, 1);
    goto_step(17555);
    chk_eq("R3", "ly frame wrap", ly, 0);
    chk_eq("R5", "mode after wrap", mode, 2);
    goto_step(17668); chk_eq("R4", "second frame line 0 not short", ly, 0);
    goto_step(17669); chk_eq("R4", "second frame line 1", ly, 1);
  endtask

  task automatic t_stat_match;
    lyc = 8'd5; stat_src_en = 4'b1000;
    lcd_start(1'b0, 1'b0);
    chk_eq("R7", "match at line 0", lyc_match, 0);
    goto_step(568);
    chk_eq("R7", "match at line 4", lyc_match, 0);
    chk_eq("R8", "no stat req before match", irq_stat, 0);
    goto_step(569);
    chk_eq("R7", "match at line 5", lyc_match, 1);
    chk_eq("R8", "stat req on match rise", irq_stat, 1);
    chk_eq("R9", "defer zero in mono", irq_defer, 0);
    goto_step(570);
    chk_eq("R8", "stat req not repeated", irq_stat, 0);
    chk_eq("R7", "match held", lyc_match, 1);
    goto_step(683);
    chk_eq("R7", "match at line 6", lyc_match, 0);
  endtask

  task automatic t_stat_combined;
    lyc = 8'd5; stat_src_en = 4'b1001;
    lcd_start(1'b0, 1'b1);
    goto_step(517);
    chk_eq("R8", "no req in line 4 draw", irq_stat, 0);
    goto_step(518);
    chk_eq("R5", "mode 0 in line 4", mode, 0);
    chk_eq("R8", "req on hblank rise", irq_stat, 1);
    chk_eq("R9", "defer stat (color)", irq_defer, 2);
    goto_step(519);
    chk_eq("R8", "hblank req one cycle", irq_stat, 0);
    goto_step(569);
    chk_eq("R7", "match line 5", lyc_match, 1);
    chk_eq("R8", "no req while level stays high", irq_stat, 0);
    stat_src_en = 4'b0000;
  endtask

  task automatic t_scroll;
    scx = 8'd0; scy = 8'h11;
    lcd_start(1'b0, 1'b0);
    goto_step(19); chk_eq("R10", "no load before window", eff_scy, 8'h00);
    goto_step(20); chk_eq("R10", "load at first boundary", eff_scy, 8'h11);
    goto_step(30); scy = 8'h22;
    goto_step(31); chk_eq("R10", "held between boundaries", eff_scy, 8'h11);
    goto_step(32); chk_eq("R10", "load at next tile", eff_scy, 8'h22);
    goto_step(70); scy = 8'h33;
    goto_step(132); chk_eq("R11", "held through hblank", eff_scy, 8'h22);
    goto_step(133); chk_eq("R10", "load in next line", eff_scy, 8'h33);
    scx = 8'd5; scy = 8'h44;
    lcd_start(1'b0, 1'b0);
    goto_step(21); chk_eq("R10", "scx 5 shifts window", eff_scy, 8'h33);
    goto_step(22); chk_eq("R10", "scx 5 load", eff_scy, 8'h44);
    scx = 8'd0;
  endtask

  task automatic t_off;
    lcd_start(1'b0, 1'b0);
    goto_step(130);
    lcd_on = 1'b0;
    scy = 8'h55;
    advance(1);
    chk_eq("R1", "ly when off", ly, 0);
    chk_eq("R1", "mode when off", mode, 0);
    chk_eq("R1", "match when off", lyc_match, 0);
    advance(40);
    chk_eq("R1", "no req when off", {irq_vblank, irq_stat}, 0);
    chk_eq("R1", "eff_scy kept when off", eff_scy, 8'h44);
  endtask

  initial begin
    rst_n = 1'b0; lcd_on = 1'b0; dbl_speed = 1'b0; color_mode = 1'b0;
    scx = '0; scy = '0; lyc = 8'd200; stat_src_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_modes();
    t_double();
    t_vblank();
    t_stat_match();
    t_stat_combined();
    t_scroll();
    t_off();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule